// File: doc/BRIEF.md
# Phase-Sequenced SPI Transaction Master

This block is a SPI master that runs one transaction as a fixed chain of phases. A start pulse launches a short prepare phase. Then come the command, address, dummy, write-data and read-data phases, each taken only when its own enable input is set. A short closing phase ends the transaction, and a one-cycle done pulse marks its end. Each shifting phase has its own programmable bit count. Command and address bits come from value inputs. Write data is taken from a 16-word, 32-bit internal buffer, and read data is stored back into the same buffer. The host loads the buffer through a write port while the block is idle and reads it back through a combinational read port.

Several controls shape the transaction. Chip select can be stretched over the prepare phase, over the closing phase, or both. A hold input with programmable polarity pauses the transaction in any phase whose hold-mask bit is set. The serial clock can be kept quiet during the dummy phase. Byte order is chosen separately for the outgoing phases and for received data. Each direction can be confined to the upper half of the buffer. A 3-wire mode turns the data line around for reads, and a full-duplex mode also captures input bits while write data is being shifted out.

Top module: `spi_phase_master`

## Requirements
- R1: Command, address, dummy, write-data and read-data phases each run only when their enable input is high. A disabled phase produces no serial clock pulses. With every phase disabled, the prepare phase goes straight to the closing phase.
- R2: Enabled phases run in the order command, address, dummy, write-data, read-data. A phase of length field L shifts L+1 bits.
- R3: When cs_setup_en is high, cs_n is low during the prepare phase. Otherwise cs_n stays high in that phase.
- R4: When cs_hold_en is high, cs_n is low during the closing phase. Otherwise cs_n stays high in that phase.
- R5: When dummy_sclk_off is high, sclk stays low for the whole dummy phase. The phase still lasts as long as when the clock is running.
- R6: hold_mask bits 0 to 5 select prepare, command, address, dummy, write-data and read-data. In a selected phase, hold_in equal to hold_pol freezes the transaction: sclk, cs_n and the bit position stay as they are. Any other hold_in value has no effect.
- R7: When tx_big is 1, the command, address and write-data bits go out most significant bit first. For command and address this means starting at bit L. When tx_big is 0, byte 0 goes first, and each byte is sent from its bit 7 down.
- R8: Received bit j is stored in word j/32 of the receive region. With rx_big set to 1 its position in the word is 31-(j mod 32). With rx_big at 0, byte (j mod 32)/8 is filled from bit 7 down.
- R9: tx_upper and rx_upper force bit 3 of the buffer word index to 1 for write-data and received data, so those accesses stay in words 8 to 15. With the bit clear, word indices run from 0.
- R10: In 3-wire mode, mosi_oe is high only during the command, address and write-data phases, and received bits are taken from dq_in. Otherwise mosi_oe is always high and received bits are taken from miso.
- R11: With full_duplex set and 3-wire mode off, miso is also sampled during the write-data phase. These bits fill the receive region ahead of the read-data bits.
- R12: A start pulse during a transaction is ignored. done is high for exactly one cycle, on the cycle after the closing phase ends, and cs_n is high from that cycle on.
- R13: sclk idles low, and every half period lasts clk_div+1 clock cycles. Data changes when sclk falls and is sampled when sclk rises. A transaction with no hold lasts (clk_div+1)*(2+2*bits) cycles from start to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a transaction when idle |
| en_cmd | input | 1 | Command phase enable |
| en_addr | input | 1 | Address phase enable |
| en_dummy | input | 1 | Dummy phase enable |
| en_wr | input | 1 | Write-data phase enable |
| en_rd | input | 1 | Read-data phase enable |
| cs_setup_en | input | 1 | Assert chip select in prepare phase |
| cs_hold_en | input | 1 | Keep chip select in closing phase |
| dummy_sclk_off | input | 1 | Keep sclk low in dummy phase |
| hold_mask | input | 6 | Per-phase hold enables |
| hold_pol | input | 1 | hold_in level that pauses |
| hold_in | input | 1 | Hold request |
| tx_big | input | 1 | Outgoing byte order |
| rx_big | input | 1 | Received byte order |
| tx_upper | input | 1 | Write data from upper buffer half |
| rx_upper | input | 1 | Received data into upper buffer half |
| three_wire | input | 1 | Shared-line half-duplex mode |
| full_duplex | input | 1 | Sample miso during write-data |
| clk_div | input | DIV_W | Half-period length minus one |
| cmd_len | input | 5 | Command bits minus one |
| addr_len | input | 5 | Address bits minus one |
| dummy_len | input | CNT_W | Dummy bits minus one |
| wr_len | input | CNT_W | Write-data bits minus one |
| rd_len | input | CNT_W | Read-data bits minus one |
| cmd_val | input | 16 | Command value |
| addr_val | input | 32 | Address value |
| buf_we | input | 1 | Buffer write strobe (idle only) |
| buf_waddr | input | 4 | Buffer write word |
| buf_wdata | input | 32 | Buffer write data |
| buf_raddr | input | 4 | Buffer read word |
| miso | input | 1 | Serial input, 4-wire |
| dq_in | input | 1 | Shared data line input, 3-wire |
| buf_rdata | output | 32 | Buffer read data |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output |
| mosi_oe | output | 1 | Output enable for the data line |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase register or a wrong bit counter shows up at the ports within the same transaction. It gives the wrong number of sclk rising edges, shifts outgoing bits to other positions, or changes the cycle count from start to done. Each of these is compared against arithmetic built from the lengths and the divider. A wrong buffer index or byte-order mapping appears after the transaction ends, when the buffer is read back and compared word by word with a model. Hold faults show up during a forced stall as sclk edges that keep counting or as a chip select that moves. Done and chip-select faults are caught on the cycle right after the closing phase.

// File: rtl/spi_phase_master.sv
module spi_phase_master #(
  parameter int CNT_W = 9,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en_cmd,
  input  logic             en_addr,
  input  logic             en_dummy,
  input  logic             en_wr,
  input  logic             en_rd,
  input  logic             cs_setup_en,
  input  logic             cs_hold_en,
  input  logic             dummy_sclk_off,
  input  logic [5:0]       hold_mask,
  input  logic             hold_pol,
  input  logic             hold_in,
  input  logic             tx_big,
  input  logic             rx_big,
  input  logic             tx_upper,
  input  logic             rx_upper,
  input  logic             three_wire,
  input  logic             full_duplex,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [4:0]       cmd_len,
  input  logic [4:0]       addr_len,
  input  logic [CNT_W-1:0] dummy_len,
  input  logic [CNT_W-1:0] wr_len,
  input  logic [CNT_W-1:0] rd_len,
  input  logic [15:0]      cmd_val,
  input  logic [31:0]      addr_val,
  input  logic             buf_we,
  input  logic [3:0]       buf_waddr,
  input  logic [31:0]      buf_wdata,
  input  logic [3:0]       buf_raddr,
  input  logic             miso,
  input  logic             dq_in,
  output logic [31:0]      buf_rdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             mosi_oe,
  output logic             done
);

  localparam int WORDS = 16;

  typedef enum logic [2:0] {
    P_IDLE, P_PREP, P_CMD, P_ADDR, P_DUMMY, P_WR, P_RD, P_DONE
  } phase_t;

  phase_t           ph, nxt;
  logic             half;
  logic [DIV_W-1:0] divcnt;
  logic [CNT_W-1:0] bitcnt, rxcnt, len;
  logic [31:0]      mem [WORDS];

  logic       shifting, tx_active, rx_en, held, tick, rbit, tbit;
  logic [7:0] hm, en_v;
  logic [4:0] tp, rp, cidx, didx, ridx;
  logic [3:0] wsum, rsum, wptr, rptr;

  assign shifting  = (ph >= P_CMD) && (ph <= P_RD);
  assign tx_active = (ph == P_CMD) || (ph == P_ADDR) || (ph == P_WR);
  assign rx_en     = (ph == P_RD) || (ph == P_WR && full_duplex && !three_wire);
  assign hm        = {1'b0, hold_mask, 1'b0};
  assign held      = hm[ph] && (hold_in == hold_pol);
  assign tick      = !held && (divcnt == clk_div);
  assign en_v      = {1'b1, en_rd, en_wr, en_dummy, en_addr, en_cmd, 2'b00};

  always_comb begin
    nxt = P_DONE;
    for (int i = 7; i >= 2; i--)
      if (en_v[i] && i > int'(ph)) nxt = phase_t'(i[2:0]);
  end

  always_comb begin
    case (ph)
      P_CMD:   len = CNT_W'(cmd_len);
      P_ADDR:  len = CNT_W'(addr_len);
      P_DUMMY: len = dummy_len;
      P_WR:    len = wr_len;
      P_RD:    len = rd_len;
      default: len = '0;
    endcase
  end

  assign tp   = bitcnt[4:0];
  assign cidx = tx_big ? (len[4:0] - tp) : {tp[4:3], ~tp[2:0]};
  assign didx = tx_big ? ~tp : {tp[4:3], ~tp[2:0]};
  assign wsum = 4'(bitcnt >> 5);
  assign wptr = {tx_upper | wsum[3], wsum[2:0]};

  assign rp   = rxcnt[4:0];
  assign ridx = rx_big ? ~rp : {rp[4:3], ~rp[2:0]};
  assign rsum = 4'(rxcnt >> 5);
  assign rptr = {rx_upper | rsum[3], rsum[2:0]};
  assign rbit = three_wire ? dq_in : miso;

  always_comb begin
    case (ph)
      P_CMD:   tbit = {16'h0, cmd_val}[cidx];
      P_ADDR:  tbit = addr_val[cidx];
      P_WR:    tbit = mem[wptr][didx];
      default: tbit = 1'b0;
    endcase
  end

  assign mosi      = tx_active && tbit;
  assign mosi_oe   = !three_wire || tx_active;
  assign sclk      = shifting && half && !(ph == P_DUMMY && dummy_sclk_off);
  assign cs_n      = !(shifting || (ph == P_PREP && cs_setup_en) ||
                       (ph == P_DONE && cs_hold_en));
  assign buf_rdata = mem[buf_raddr];

  always_ff @(posedge clk) begin
    if (ph == P_IDLE && buf_we)
      mem[buf_waddr] <= buf_wdata;
    else if (tick && rx_en && !half)
      mem[rptr][ridx] <= rbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= P_IDLE;
      half   <= 1'b0;
      divcnt <= '0;
      bitcnt <= '0;
      rxcnt  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == P_IDLE) begin
        if (start) begin
          ph     <= P_PREP;
          half   <= 1'b0;
          divcnt <= '0;
          bitcnt <= '0;
          rxcnt  <= '0;
        end
      end else if (!held) begin
        if (divcnt != clk_div) begin
          divcnt <= divcnt + 1'b1;
        end else begin
          divcnt <= '0;
          if (ph == P_PREP) begin
            ph <= nxt;
          end else if (ph == P_DONE) begin
            ph   <= P_IDLE;
            done <= 1'b1;
          end else if (!half) begin
            half <= 1'b1;
            if (rx_en) rxcnt <= rxcnt + 1'b1;
          end else begin
            half <= 1'b0;
            if (bitcnt == len) begin
              bitcnt <= '0;
              ph     <= nxt;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
      end
    end
  end

  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph == P_IDLE || ph >= $past(ph)));  // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ($stable(ph) && $stable(bitcnt) && $stable(half) && $stable(divcnt)));  // R6
  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !(ph == P_DUMMY && dummy_sclk_off));  // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != P_IDLE && start) |=> (ph != P_PREP || $past(ph) == P_PREP));  // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R12
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);  // R12
  AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);  // R13

endmodule

// File: tb/spi_phase_master_bench.sv
module spi_phase_master_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic en_cmd = 1, en_addr = 1, en_dummy = 1, en_wr = 1, en_rd = 1;
  logic cs_setup_en = 1, cs_hold_en = 1, dummy_sclk_off = 0;
  logic [5:0] hold_mask = '0;
  logic hold_pol = 1'b1, hold_in = 1'b0;
  logic tx_big = 1, rx_big = 1, tx_upper = 0, rx_upper = 0;
  logic three_wire = 0, full_duplex = 0;
  logic [7:0] clk_div = 8'd1;
  logic [4:0] cmd_len = 5'd7, addr_len = 5'd11;
  logic [8:0] dummy_len = 9'd3, wr_len = 9'd39, rd_len = 9'd35;
  logic [15:0] cmd_val = 16'h00C5;
  logic [31:0] addr_val = 32'h0000_A3E9;
  logic buf_we = 0;
  logic [3:0] buf_waddr = '0, buf_raddr = '0;
  logic [31:0] buf_wdata = '0;
  logic miso = 0, dq_in = 0;
  logic [31:0] buf_rdata;
  logic cs_n, sclk, mosi, mosi_oe, done;

  spi_phase_master u_spi_phase_master (
    .clk(clk), .rst_n(rst_n), .start(start),
    .en_cmd(en_cmd), .en_addr(en_addr), .en_dummy(en_dummy), .en_wr(en_wr), .en_rd(en_rd),
    .cs_setup_en(cs_setup_en), .cs_hold_en(cs_hold_en), .dummy_sclk_off(dummy_sclk_off),
    .hold_mask(hold_mask), .hold_pol(hold_pol), .hold_in(hold_in),
    .tx_big(tx_big), .rx_big(rx_big), .tx_upper(tx_upper), .rx_upper(rx_upper),
    .three_wire(three_wire), .full_duplex(full_duplex), .clk_div(clk_div),
    .cmd_len(cmd_len), .addr_len(addr_len), .dummy_len(dummy_len),
    .wr_len(wr_len), .rd_len(rd_len), .cmd_val(cmd_val), .addr_val(addr_val),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .miso(miso), .dq_in(dq_in), .buf_rdata(buf_rdata),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe), .done(done)
  );

  int checks = 0, errors = 0, nrise = 0, done_cnt = 0;
  logic cap_b [0:1023];
  logic cap_oe [0:1023];
  logic [31:0] exp_mem [16];

  function automatic logic pat(int n);
    return (((n * n + 3 * n) >> 2) % 2) == 1;
  endfunction

  function automatic logic ord_bit(logic [31:0] v, int w, logic big, int k);
    int idx;
    idx = big ? (w - 1 - k) : ((k / 8) * 8 + 7 - k % 8);
    return v[idx];
  endfunction

  function automatic int wptr(logic up, int k);
    return ((k / 32) % 16) | (up ? 8 : 0);
  endfunction

  function automatic int didx(logic big, int k);
    int p;
    p = k % 32;
    return big ? (31 - p) : ((p / 8) * 8 + 7 - p % 8);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge sclk) begin
    if (nrise < 1024) begin
      cap_b[nrise]  = mosi;
      cap_oe[nrise] = mosi_oe;
    end
    nrise++;
    miso  = three_wire ? !pat(nrise) : pat(nrise);
    dq_in = three_wire ? pat(nrise) : !pat(nrise);
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic load_buf(input int seed);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      buf_we = 1'b1;
      buf_waddr = 4'(i);
      buf_wdata = 32'(i * 32'h0101_0101 + seed * 32'h1111_1111) ^ 32'hA5C3_0F96;
      exp_mem[i] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic run_txn(input string tag, input bit chk_cyc);
    int c, a, dm, dclk, w, r, bits, n, pos, bad, oebad, j, base;
    logic cs_first, last_cs, got, b, eb;
    c  = en_cmd ? int'(cmd_len) + 1 : 0;
    a  = en_addr ? int'(addr_len) + 1 : 0;
    dm = en_dummy ? int'(dummy_len) + 1 : 0;
    w  = en_wr ? int'(wr_len) + 1 : 0;
    r  = en_rd ? int'(rd_len) + 1 : 0;
    dclk = dummy_sclk_off ? 0 : dm;
    bits = c + a + dm + w + r;
    nrise = 0;
    miso  = three_wire ? !pat(0) : pat(0);
    dq_in = three_wire ? pat(0) : !pat(0);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    cs_first = cs_n; last_cs = cs_n; got = 0; n = 0;
    while (!got && n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) got = 1; else last_cs = cs_n;
    end
    check(got, "R12", {tag, " done seen"}, got, 1);
    check(cs_n == 1'b1, "R12", {tag, " cs released with done"}, cs_n, 1);
    if (chk_cyc)
      check(n == (int'(clk_div) + 1) * (2 + 2 * bits), "R13", {tag, " cycles"},
            n, (int'(clk_div) + 1) * (2 + 2 * bits));
    check(nrise == c + a + dclk + w + r, "R1/R5", {tag, " sclk rises"}, nrise, c + a + dclk + w + r);
    check(cs_first == !cs_setup_en, "R3", {tag, " cs in prepare"}, cs_first, !cs_setup_en);
    check(last_cs == !cs_hold_en, "R4", {tag, " cs in closing"}, last_cs, !cs_hold_en);
    @(negedge clk);
    check(done == 1'b0 && sclk == 1'b0, "R12", {tag, " done width"}, done, 0);
    bad = 0; oebad = 0; pos = 0;
    for (int k = 0; k < c; k++) begin
      eb = ord_bit({16'h0, cmd_val}, c, tx_big, k);
      if (cap_b[pos + k] !== eb) bad++;
      if (cap_oe[pos + k] !== 1'b1) oebad++;
    end
    pos += c;
    for (int k = 0; k < a; k++) begin
      eb = ord_bit(addr_val, a, tx_big, k);
      if (cap_b[pos + k] !== eb) bad++;
      if (cap_oe[pos + k] !== 1'b1) oebad++;
    end
    pos += a + dclk;
    for (int k = 0; k < w; k++) begin
      eb = exp_mem[wptr(tx_upper, k)][didx(tx_big, k)];
      if (cap_b[pos + k] !== eb) bad++;
      if (cap_oe[pos + k] !== 1'b1) oebad++;
    end
    pos += w;
    for (int k = 0; k < r; k++)
      if (cap_oe[pos + k] !== !three_wire) oebad++;
    check(bad == 0, "R2/R7/R9", {tag, " outgoing bit mismatches"}, bad, 0);
    check(oebad == 0, "R10", {tag, " output enable mismatches"}, oebad, 0);
    j = 0;
    base = c + a + dclk;
    if (full_duplex && !three_wire)
      for (int k = 0; k < w; k++) begin
        b = pat(base + k);
        exp_mem[wptr(rx_upper, j)][didx(rx_big, j)] = b;
        j++;
      end
    base += w;
    for (int k = 0; k < r; k++) begin
      b = pat(base + k);
      exp_mem[wptr(rx_upper, j)][didx(rx_big, j)] = b;
      j++;
    end
    for (int i = 0; i < 16; i++) begin
      buf_raddr = 4'(i);
      #1;
      check(buf_rdata === exp_mem[i], "R8/R9/R11", $sformatf("%s word %0d", tag, i),
            buf_rdata, exp_mem[i]);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    check(cs_n == 1 && sclk == 0 && done == 0, "R13", "reset outputs",
          {cs_n, sclk, done}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    load_buf(1);
    run_txn("base", 1);

    for (int m = 0; m < 32; m++) begin
      {en_rd, en_wr, en_dummy, en_addr, en_cmd} = 5'(m);
      cs_setup_en = m[0] ^ m[2];
      cs_hold_en = m[1];
      dummy_sclk_off = m[3] ^ m[4];
      clk_div = 8'(m % 3);
      tx_big = m[2]; rx_big = m[3];
      load_buf(m + 2);
      run_txn($sformatf("R1 sweep%0d", m), 1);
    end

    {en_rd, en_wr, en_dummy, en_addr, en_cmd} = 5'h1F;
    cs_setup_en = 1; cs_hold_en = 1; dummy_sclk_off = 0; clk_div = 0;
    wr_len = 9'd71; rd_len = 9'd100;
    for (int o = 0; o < 16; o++) begin
      {rx_upper, tx_upper, rx_big, tx_big} = 4'(o);
      load_buf(o + 40);
      run_txn($sformatf("R7 R8 R9 order%0d", o), 1);
    end

    tx_upper = 0; rx_upper = 1; clk_div = 2;
    three_wire = 1;
    load_buf(60);
    run_txn("R10 three-wire", 1);
    three_wire = 0; full_duplex = 1;
    load_buf(61);
    run_txn("R11 full-duplex", 1);
    full_duplex = 0;

    wr_len = 9'd39; rd_len = 9'd35; clk_div = 1;
    hold_mask = 6'b001000; hold_pol = 1; hold_in = 1;
    load_buf(70);
    fork
      run_txn("R6 hold dummy", 0);
      begin
        repeat (300) @(negedge clk);
        check(nrise == 20, "R6", "stall in dummy rises", nrise, 20);
        check(cs_n == 0 && sclk == 0, "R6", "stall in dummy lines", {cs_n, sclk}, 0);
        hold_in = 0;
      end
    join

    hold_mask = 6'b111111; hold_pol = 0; hold_in = 1;
    load_buf(71);
    run_txn("R6 wrong level no hold", 1);

    hold_mask = 6'b000001; hold_pol = 0; hold_in = 0; cs_setup_en = 0;
    load_buf(72);
    fork
      run_txn("R6 hold prepare", 0);
      begin
        repeat (200) @(negedge clk);
        check(nrise == 0 && cs_n == 1, "R6", "stall in prepare", {nrise[3:0], cs_n}, 1);
        hold_in = 1;
      end
    join
    hold_mask = '0; cs_setup_en = 1;

    load_buf(73);
    d0 = done_cnt;
    fork
      run_txn("R12 start while busy", 1);
      begin
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (30) @(negedge clk);
    check(done_cnt - d0 == 1 && cs_n == 1, "R12", "single done after mid start",
          done_cnt - d0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule